// File: doc/BRIEF.md
# Two-Pin Multi-Purpose I/O Controller

This block runs two general-purpose pads from one 32-bit configuration word. A 2-bit mode field per pad makes it a plain input, an inverted input, or an output that drives a fixed low or high level. Every pad also has a "level" that the logic uses: the synchronized pad input, inverted when the mode asks for it, or the driven level when the pad is an output.

Two sets of per-pad enable bits route these levels onward. The first set lets a pad raise a sticky power-management event flag, which software clears by pulsing a clear input. The second set lets a pad take part in a power-down request, which is the OR of the levels of the enabled pads.

The register can be written from a simple write port, or from a parallel load port that stands in for a boot-time preload. The load port wins when both are used in the same cycle.

Top module: `mpio_pair`

## Requirements
- R1: After a synchronous active-low reset, every configuration bit is 0. The read data is 0, both output enables and output values are 0, and the event flag and the power-down request are 0.
- R2: A write stores bits [7:0] of the write data, and the stored value appears on the read data from the next cycle on. Read bits [31:8] are always 0, whatever was written to them.
- R3: Bits [1:0] hold the mode of pad 0 and bits [3:2] hold the mode of pad 1. Mode 00 is a plain input: the pad's level equals its synchronized input.
- R4: Mode 01 is an inverted input: the pad's level is the synchronized input inverted.
- R5: Mode 10 drives the pad low and mode 11 drives it high, with output enable 1 and a level equal to the driven value. In both input modes the output enable is 0 and the output value is 0.
- R6: A pad input passes through two flip-flops. A change applied just after a clock edge reaches the levels after the second following edge and not after the first.
- R7: Bit 4 (pad 0) and bit 5 (pad 1) enable a pad to set the event flag. The flag goes to 1 one cycle after an enabled pad's level becomes 1. A pad whose bit is 0 never sets it.
- R8: The event flag stays set until the clear input is 1 at a clock edge. If an enabled pad's level is still 1 at that edge, setting wins and the flag stays 1.
- R9: Bit 6 (pad 0) and bit 7 (pad 1) enable a pad into the power-down request. The request is the OR of the levels of the enabled pads and ignores the pads that are not enabled.
- R10: A load pulse copies the 8-bit load data into the defined bits. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word, upper bits zero |
| load_en | input | 1 | Parallel preload strobe |
| load_data | input | 8 | Preload value for the defined bits |
| pad_in | input | 2 | Pad input values, asynchronous |
| pad_oe | output | 2 | Pad output enables |
| pad_out | output | 2 | Pad output values |
| evt_clr | input | 1 | Clears the event flag |
| evt_status | output | 1 | Sticky power-management event flag |
| pwrdn_req | output | 1 | Power-down request |

## Verification
Pad levels are observed through the power-down request. Input patterns that raise only the enabled pad, only the masked pad, and both pads separate correct gating from a plain OR of the pads. The same patterns are applied under plain and inverted modes, which tells the two polarities apart, and a single-edge sample catches a synchronizer that is too short. The output modes are tried with both drive levels and both pad orders, so that swapped fields or a swapped drive level show up. For the event flag, the stimulus separates a disabled pad from an enabled one and a sticky hold from a level-following flag, and it also checks a clear that arrives while the set condition is still active.

// File: rtl/mpio_pkg.sv
// Package: shared mode encoding and level decode for the pad controller.
// Assumes a 2-bit mode field per pad; bit [1] selects output drive.
package mpio_pkg;

    typedef enum logic [1:0] {
        MODE_IN_PLAIN = 2'b00,
        MODE_IN_INV   = 2'b01,
        MODE_OUT_LO   = 2'b10,
        MODE_OUT_HI   = 2'b11
    } pin_mode_e;

    // Level of a pad as seen by downstream logic.
    function automatic logic pin_level(input pin_mode_e mode, input logic sync_in);
        logic lvl;
        case (mode)
            MODE_IN_PLAIN: lvl = sync_in;
            MODE_IN_INV:   lvl = ~sync_in;
            MODE_OUT_LO:   lvl = 1'b0;
            default:       lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/mpio_cfg_reg.sv
// Configuration register: holds the defined low bits, loaded either from the
// preload port or the write port (preload has priority). Assumes REG_W > DEF_W.
module mpio_cfg_reg #(
    parameter int REG_W = 32,
    parameter int DEF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             load_en,
    input  logic [DEF_W-1:0] load_data,
    output logic [DEF_W-1:0] cfg_q,
    output logic [REG_W-1:0] cfg_rdata
);

    logic unused_hi;

    // Bits above the defined field are discarded.
    assign unused_hi = ^cfg_wdata[REG_W-1:DEF_W];

    // Register update: reset, then preload, then write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load_en)
            cfg_q <= load_data;
        else if (cfg_wr)
            cfg_q <= cfg_wdata[DEF_W-1:0];
    end

    // Read path: reserved bits return zero.
    always_comb begin
        cfg_rdata = '0;
        cfg_rdata[DEF_W-1:0] = cfg_q;
    end

    assert_load_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cfg_q == $past(load_data));

    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !load_en) |=> cfg_q == $past(cfg_wdata[DEF_W-1:0]));

endmodule

// File: rtl/mpio_pin.sv
// One pad: two-flop input synchronizer, mode-driven tri-state drive and the
// level seen by the event and power-down logic. Assumes pad_in is asynchronous.
module mpio_pin
    import mpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      pad_in,
    output logic      pad_oe,
    output logic      pad_out,
    output logic      level
);

    logic sync_a;
    logic sync_b;

    // Two-stage synchronizer for the pad input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= pad_in;
            sync_b <= sync_a;
        end
    end

    // Drive and level decode from the mode field.
    always_comb begin
        pad_oe  = mode[1];
        pad_out = mode[1] & mode[0];
        level   = pin_level(mode, sync_b);
    end

    assert_sync_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && !mode[1])
            |-> level == ($past(pad_in, 2) ^ mode[0]));

endmodule

// File: rtl/mpio_event.sv
// Sticky event flag and power-down request from the per-pad levels.
// Assumes levels are already synchronized; setting wins over clearing.
module mpio_event #(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] evt_en,
    input  logic [NUM_PINS-1:0] pd_en,
    input  logic                evt_clr,
    output logic                evt_status,
    output logic                pwrdn_req
);

    logic evt_set;

    // Combine enabled pad levels.
    always_comb begin
        evt_set   = |(level & evt_en);
        pwrdn_req = |(level & pd_en);
    end

    // Sticky flag with software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_status <= 1'b0;
        else if (evt_set)
            evt_status <= 1'b1;
        else if (evt_clr)
            evt_status <= 1'b0;
    end

    assert_evt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(level & evt_en)) |=> evt_status);

    assert_evt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status && !evt_clr) |=> evt_status);

    assert_evt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !(|(level & evt_en))) |=> !evt_status);

endmodule

// File: rtl/mpio_pair.sv
// Top: multi-purpose pad controller. One configuration word sets per-pad mode,
// event enable and power-down enable; field offsets derive from NUM_PINS.
module mpio_pair
    import mpio_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int REG_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                load_en,
    input  logic [4*NUM_PINS-1:0] load_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    input  logic                evt_clr,
    output logic                evt_status,
    output logic                pwrdn_req
);

    localparam int DEF_W   = 4 * NUM_PINS;
    localparam int EVT_OFS = 2 * NUM_PINS;
    localparam int PD_OFS  = 3 * NUM_PINS;

    logic [DEF_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] level;

    mpio_cfg_reg #(.REG_W(REG_W), .DEF_W(DEF_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .load_en   (load_en),
        .load_data (load_data),
        .cfg_q     (cfg_q),
        .cfg_rdata (cfg_rdata)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        mpio_pin i_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (pin_mode_e'(cfg_q[2*i +: 2])),
            .pad_in  (pad_in[i]),
            .pad_oe  (pad_oe[i]),
            .pad_out (pad_out[i]),
            .level   (level[i])
        );
    end

    mpio_event #(.NUM_PINS(NUM_PINS)) i_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .evt_en     (cfg_q[EVT_OFS +: NUM_PINS]),
        .pd_en      (cfg_q[PD_OFS +: NUM_PINS]),
        .evt_clr    (evt_clr),
        .evt_status (evt_status),
        .pwrdn_req  (pwrdn_req)
    );

endmodule

// File: tb/test_mpio_pair.sv
// Scoreboard bench: the driver pushes expected output sets, the monitor
// compares them at the falling edge.
module test_mpio_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        load_en = 1'b0;
    logic [7:0]  load_data = '0;
    logic [1:0]  pad_in = '0;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;
    logic        evt_clr = 1'b0;
    logic        evt_status;
    logic        pwrdn_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0]  oe;
        logic [1:0]  out;
        logic        evt;
        logic        pd;
        logic [31:0] rd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  mon_e;
    exp_t  mon_a;
    string mon_t;

    always #2 clk = ~clk;

    mpio_pair i_mpio_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .load_en    (load_en),
        .load_data  (load_data),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .evt_clr    (evt_clr),
        .evt_status (evt_status),
        .pwrdn_req  (pwrdn_req)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [7:0] cfg, input logic [1:0] pad, input logic evt);
        exp_t e;
        logic [1:0] lvl;
        for (int i = 0; i < 2; i++) begin
            logic [1:0] m;
            m = cfg[2*i +: 2];
            lvl[i]   = m[1] ? m[0] : (pad[i] ^ m[0]);
            e.oe[i]  = m[1];
            e.out[i] = m[1] & m[0];
        end
        e.evt = evt;
        e.pd  = |(lvl & cfg[7:6]);
        e.rd  = {24'b0, cfg};
        return e;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string tag, input exp_t e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic write_cfg(input logic [31:0] d);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        step();
        cfg_wr = 1'b0;
    endtask

    // Monitor: compare queued expectations against the outputs.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            mon_a = '{oe: pad_oe, out: pad_out, evt: evt_status, pd: pwrdn_req, rd: cfg_rdata};
            checks++;
            if (mon_a !== mon_e) begin
                failures++;
                $display("FAIL %s: actual oe=%b out=%b evt=%b pd=%b rd=%h expected oe=%b out=%b evt=%b pd=%b rd=%h",
                         mon_t, mon_a.oe, mon_a.out, mon_a.evt, mon_a.pd, mon_a.rd,
                         mon_e.oe, mon_e.out, mon_e.evt, mon_e.pd, mon_e.rd);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        expect_now("R1 reset state", model(8'h00, 2'b00, 1'b0));

        // R2: upper bits ignored, lower bits stored.
        write_cfg(32'hFFFF_FF00);
        expect_now("R2 reserved bits read zero", model(8'h00, 2'b00, 1'b0));
        write_cfg(32'h1234_56C0);
        expect_now("R2 defined bits stored", model(8'hC0, 2'b00, 1'b0));

        // R3/R6: plain input, two-flop latency.
        pad_in = 2'b01;
        step();
        expect_now("R6 not visible after one edge", model(8'hC0, 2'b00, 1'b0));
        step();
        expect_now("R3 R6 pad0 plain visible", model(8'hC0, 2'b01, 1'b0));

        // R9: only pad 0 enabled into power-down.
        write_cfg(32'h0000_0040);
        pad_in = 2'b10;
        step(); step();
        expect_now("R9 masked pad1 ignored", model(8'h40, 2'b10, 1'b0));
        pad_in = 2'b11;
        step(); step();
        expect_now("R9 enabled pad0 requests", model(8'h40, 2'b11, 1'b0));

        // R4: pad 1 inverted.
        write_cfg(32'h0000_0084);
        pad_in = 2'b10;
        step(); step();
        expect_now("R4 inverted high gives low", model(8'h84, 2'b10, 1'b0));
        pad_in = 2'b00;
        step(); step();
        expect_now("R4 inverted low gives high", model(8'h84, 2'b00, 1'b0));

        // R5: output modes, both orders.
        write_cfg(32'h0000_00CE);
        expect_now("R5 pad0 low pad1 high", model(8'hCE, 2'b00, 1'b0));
        write_cfg(32'h0000_004B);
        expect_now("R5 pad0 high pad1 low", model(8'h4B, 2'b00, 1'b0));

        // R7: event enable gating.
        write_cfg(32'h0000_0020);
        pad_in = 2'b01;
        step(); step(); step();
        expect_now("R7 disabled pad0 no event", model(8'h20, 2'b01, 1'b0));
        pad_in = 2'b10;
        step(); step();
        expect_now("R7 event not yet set", model(8'h20, 2'b10, 1'b0));
        step();
        expect_now("R7 enabled pad1 sets event", model(8'h20, 2'b10, 1'b1));

        // R8: sticky, clear, set wins.
        pad_in = 2'b00;
        step(); step(); step();
        expect_now("R8 flag sticky", model(8'h20, 2'b00, 1'b1));
        evt_clr = 1'b1;
        step();
        evt_clr = 1'b0;
        expect_now("R8 clear", model(8'h20, 2'b00, 1'b0));
        pad_in = 2'b10;
        step(); step(); step();
        evt_clr = 1'b1;
        step();
        evt_clr = 1'b0;
        expect_now("R8 set wins over clear", model(8'h20, 2'b10, 1'b1));
        pad_in = 2'b00;
        step(); step();
        evt_clr = 1'b1;
        step();
        evt_clr = 1'b0;
        expect_now("R8 clear after source drops", model(8'h20, 2'b00, 1'b0));

        // R10: load beats write.
        load_en = 1'b1;
        load_data = 8'h8C;
        cfg_wr = 1'b1;
        cfg_wdata = 32'h0000_0001;
        step();
        load_en = 1'b0;
        cfg_wr = 1'b0;
        expect_now("R10 load priority", model(8'h8C, 2'b00, 1'b0));

        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule